// File: doc/BRIEF.md
# Per-Chip DRAM Power-Mode Controller

This block manages the power mode of a small bank of DRAM devices laid out as a flat, non-interleaved main memory. The top address bits pick one device, and only that device is woken for a request. Every device moves through four modes on its own. Active costs the most power and needs no wake-up time. Standby, Nap and PowerDown each save more power and each has a longer wake-up delay, set in clock cycles.

One request is held at a time. When a request is accepted, its device goes to Active at once and the request is held until that device's wake-up delay has run out. The block then grants the request, returns the granted address and device index, and frees itself for the next request.

While a device has nothing outstanding, one of two policies lowers its mode. The quad policy steps the device down one mode at a time after a programmable idle time for each step. The dual policy drops an idle device straight to one shared base mode. Software can also force any idle device into any mode.

Top module: `dram_pwr_ctrl`

## Requirements
- R1: The target device of a request is address bits [CHIP_AW+IDX_W-1:CHIP_AW], which is the address divided by the per-device size (2^CHIP_AW words). The grant reports this index and the full address.
- R2: After reset, every device reads Active, req_ready is 1 and grant is 0.
- R3: Accepting a request (req_valid and req_ready at a rising edge) sets the target device to Active at that edge, whatever its prior mode.
- R4: The grant goes high exactly L cycles after the accepting edge and stays high for one cycle. L is 0 if the device was Active before acceptance, wake_stby if it was Standby, wake_nap if Nap and wake_pdn if PowerDown.
- R5: Only one request is held at a time. req_ready is 0 from the accepting edge until the edge that ends the grant cycle, and is 1 after that edge.
- R6: In quad mode (quad_mode=1), an idle device with threshold T for its current step moves down one mode at the (T+1)th edge of idleness. The steps are Active to Standby (thr_a2s), Standby to Nap (thr_s2n) and Nap to PowerDown (thr_n2p). PowerDown is held.
- R7: A threshold of 0 moves the device at the first edge after it becomes idle.
- R8: In dual mode (quad_mode=0), a device with a held request stays Active. Any idle device whose mode differs from base_state moves to base_state at the next edge.
- R9: Idleness is counted per device and only while that device has no held request. Accesses to one device do not disturb another device's mode.
- R10: A force_valid pulse sets device force_chip to force_state at the next edge, unless that device has a held request or is being accessed. In those cases the force is ignored.
- R11: Mode encoding is Active=0, Standby=1, Nap=2, PowerDown=3. Device i is reported on chip_state[2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request word address |
| req_ready | output | 1 | Block can accept a request |
| grant | output | 1 | One-cycle issue strobe for the held request |
| grant_chip | output | IDX_W | Device index of the granted request |
| grant_addr | output | ADDR_W | Address of the granted request |
| quad_mode | input | 1 | 1 = stepwise threshold policy, 0 = single base mode policy |
| base_state | input | 2 | Base mode used in dual mode |
| thr_a2s | input | CNT_W | Idle cycles before Active to Standby |
| thr_s2n | input | CNT_W | Idle cycles before Standby to Nap |
| thr_n2p | input | CNT_W | Idle cycles before Nap to PowerDown |
| wake_stby | input | LAT_W | Wake-up cycles from Standby |
| wake_nap | input | LAT_W | Wake-up cycles from Nap |
| wake_pdn | input | LAT_W | Wake-up cycles from PowerDown |
| force_valid | input | 1 | Software mode override strobe |
| force_chip | input | IDX_W | Device to override |
| force_state | input | 2 | Mode to force |
| chip_state | output | 2*NCHIP | Packed mode of each device |

## Verification
The assertions check on every cycle that an accepted request sets its device to Active. They also check that a device with a held request stays Active, that a grant only goes to an Active device, and that in quad mode a mode change without an access or force is never more than one step down. They also cover the handshake: ready drops after acceptance and comes back after the grant. The exact cycle counts need the bench's scenarios: the grant falling exactly the mode's wake-up delay after acceptance, and each threshold boundary including zero. So does the dual-mode return to the base mode, and an override being ignored on a busy device.

// File: rtl/dram_pwr_pkg.sv
// Shared mode type and helpers for the DRAM power-mode controller.
// Assumes the mode encoding below is visible to software as-is.
package dram_pwr_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_STBY   = 2'd1,
        PS_NAP    = 2'd2,
        PS_PDN    = 2'd3
    } pstate_e;

    // Next lower-power mode; PowerDown maps to itself.
    function automatic pstate_e step_down(input pstate_e s);
        case (s)
            PS_ACTIVE: step_down = PS_STBY;
            PS_STBY:   step_down = PS_NAP;
            default:   step_down = PS_PDN;
        endcase
    endfunction

endpackage

// File: rtl/dram_pwr_chip.sv
// Mode tracker for one DRAM device: holds its mode, counts idle cycles
// toward the next lower mode, and counts down the wake-up delay after an
// access. Assumes the access, pending and force strobes come from the
// request holder and are never asserted together with pending on access.
module dram_pwr_chip
    import dram_pwr_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int LAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             quad_i,
    input  pstate_e          base_i,
    input  logic [CNT_W-1:0] thr_as_i,
    input  logic [CNT_W-1:0] thr_sn_i,
    input  logic [CNT_W-1:0] thr_np_i,
    input  logic [LAT_W-1:0] lat_sb_i,
    input  logic [LAT_W-1:0] lat_nap_i,
    input  logic [LAT_W-1:0] lat_pd_i,
    input  logic             access_i,
    input  logic             pending_i,
    input  logic             frc_i,
    input  pstate_e          frc_state_i,
    output pstate_e          state_o,
    output logic             wake_done_o
);

    pstate_e          state_q;
    logic [CNT_W-1:0] idle_q;
    logic [LAT_W-1:0] wake_q;
    logic [CNT_W-1:0] thr_sel;
    logic [LAT_W-1:0] lat_sel;

    // Pick the idle threshold for the step out of the current mode.
    always_comb begin
        case (state_q)
            PS_ACTIVE: thr_sel = thr_as_i;
            PS_STBY:   thr_sel = thr_sn_i;
            default:   thr_sel = thr_np_i;
        endcase
    end

    // Pick the wake-up delay paid when leaving the current mode.
    always_comb begin
        case (state_q)
            PS_ACTIVE: lat_sel = '0;
            PS_STBY:   lat_sel = lat_sb_i;
            PS_NAP:    lat_sel = lat_nap_i;
            default:   lat_sel = lat_pd_i;
        endcase
    end

    // Mode, idle count and wake countdown update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
            idle_q  <= '0;
            wake_q  <= '0;
        end else if (access_i) begin
            state_q <= PS_ACTIVE;
            idle_q  <= '0;
            wake_q  <= lat_sel;
        end else begin
            if (wake_q != '0) wake_q <= wake_q - 1'b1;
            if (pending_i) begin
                idle_q <= '0;
            end else if (frc_i) begin
                state_q <= frc_state_i;
                idle_q  <= '0;
            end else if (!quad_i) begin
                if (state_q != base_i) state_q <= base_i;
                idle_q <= '0;
            end else if (state_q != PS_PDN) begin
                if (idle_q >= thr_sel) begin
                    state_q <= step_down(state_q);
                    idle_q  <= '0;
                end else begin
                    idle_q <= idle_q + 1'b1;
                end
            end
        end
    end

    assign state_o     = state_q;
    assign wake_done_o = (wake_q == '0);

    // R3: an access always lands the device in Active.
    p_access_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        access_i |=> state_q == PS_ACTIVE);

    // R8: a device with a held request never leaves Active.
    p_pending_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> state_q == PS_ACTIVE);

    // R6: without access or force, quad mode moves at most one step down.
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_i && !access_i && !frc_i) |=>
            (state_q == $past(state_q)) || (int'(state_q) == int'($past(state_q)) + 1));

endmodule

// File: rtl/dram_pwr_req.sv
// Single-entry request holder: accepts one request, marks its device as
// accessed and pending, and grants once that device's wake-up countdown
// is done. Assumes wake_done_i comes from registered device state.
module dram_pwr_req #(
    parameter int NCHIP  = 4,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [IDX_W-1:0]  req_chip_i,
    input  logic [NCHIP-1:0]  wake_done_i,
    output logic              req_ready_o,
    output logic              grant_o,
    output logic [IDX_W-1:0]  grant_chip_o,
    output logic [ADDR_W-1:0] grant_addr_o,
    output logic [NCHIP-1:0]  access_o,
    output logic [NCHIP-1:0]  pending_o
);

    logic              busy_q;
    logic [IDX_W-1:0]  tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    assign accept      = req_valid_i && !busy_q;
    assign req_ready_o = !busy_q;
    assign grant_o     = busy_q && wake_done_i[tgt_q];

    // Per-device access and pending strobes.
    for (genvar i = 0; i < NCHIP; i++) begin : g_strb
        assign access_o[i]  = accept && (req_chip_i == IDX_W'(i));
        assign pending_o[i] = busy_q && (tgt_q == IDX_W'(i));
    end

    // Hold the request from acceptance to grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tgt_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            tgt_q  <= req_chip_i;
            addr_q <= req_addr_i;
        end else if (grant_o) begin
            busy_q <= 1'b0;
        end
    end

    assign grant_chip_o = tgt_q;
    assign grant_addr_o = addr_q;

    // R5: acceptance closes the door to further requests.
    p_one_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R5: a grant frees the holder for the next request.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> req_ready_o && !grant_o);

endmodule

// File: rtl/dram_pwr_ctrl.sv
// Top of the per-device DRAM power-mode controller. Splits the address
// into a device index (non-interleaved), holds one request, and runs one
// mode tracker per device. Assumes configuration inputs are static while
// requests are in flight.
module dram_pwr_ctrl
    import dram_pwr_pkg::*;
#(
    parameter int NCHIP   = 4,
    parameter int CHIP_AW = 10,
    parameter int CNT_W   = 20,
    parameter int LAT_W   = 12,
    localparam int IDX_W  = (NCHIP > 1) ? $clog2(NCHIP) : 1,
    localparam int ADDR_W = CHIP_AW + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               grant,
    output logic [IDX_W-1:0]   grant_chip,
    output logic [ADDR_W-1:0]  grant_addr,
    input  logic               quad_mode,
    input  logic [1:0]         base_state,
    input  logic [CNT_W-1:0]   thr_a2s,
    input  logic [CNT_W-1:0]   thr_s2n,
    input  logic [CNT_W-1:0]   thr_n2p,
    input  logic [LAT_W-1:0]   wake_stby,
    input  logic [LAT_W-1:0]   wake_nap,
    input  logic [LAT_W-1:0]   wake_pdn,
    input  logic               force_valid,
    input  logic [IDX_W-1:0]   force_chip,
    input  logic [1:0]         force_state,
    output logic [2*NCHIP-1:0] chip_state
);

    logic [IDX_W-1:0] req_chip;
    logic [NCHIP-1:0] wake_done;
    logic [NCHIP-1:0] access;
    logic [NCHIP-1:0] pending;
    pstate_e          st [NCHIP];

    // Non-interleaved split: device index is the address above the device size.
    assign req_chip = req_addr[CHIP_AW +: IDX_W];

    dram_pwr_req #(
        .NCHIP (NCHIP),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .req_chip_i  (req_chip),
        .wake_done_i (wake_done),
        .req_ready_o (req_ready),
        .grant_o     (grant),
        .grant_chip_o(grant_chip),
        .grant_addr_o(grant_addr),
        .access_o    (access),
        .pending_o   (pending)
    );

    for (genvar i = 0; i < NCHIP; i++) begin : g_chip
        logic frc_hit;
        assign frc_hit = force_valid && (force_chip == IDX_W'(i));

        dram_pwr_chip #(
            .CNT_W(CNT_W),
            .LAT_W(LAT_W)
        ) u_chip (
            .clk        (clk),
            .rst_n      (rst_n),
            .quad_i     (quad_mode),
            .base_i     (pstate_e'(base_state)),
            .thr_as_i   (thr_a2s),
            .thr_sn_i   (thr_s2n),
            .thr_np_i   (thr_n2p),
            .lat_sb_i   (wake_stby),
            .lat_nap_i  (wake_nap),
            .lat_pd_i   (wake_pdn),
            .access_i   (access[i]),
            .pending_i  (pending[i]),
            .frc_i      (frc_hit),
            .frc_state_i(pstate_e'(force_state)),
            .state_o    (st[i]),
            .wake_done_o(wake_done[i])
        );

        assign chip_state[2*i +: 2] = st[i];
    end

    // R4: a request is only issued to a device that is Active.
    p_grant_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> st[grant_chip] == PS_ACTIVE);

endmodule

// File: tb/dram_pwr_ctrl_tb.sv
// Scoreboard bench: the driver queues the expected grant (device, cycle,
// address); a monitor pops and compares on every grant.
module dram_pwr_ctrl_tb;

    localparam int NCHIP = 4, CHIP_AW = 10, CNT_W = 20, LAT_W = 12;
    localparam int IDX_W = 2, ADDR_W = 12;
    localparam int TAS = 2, TSN = 3, TNP = 4;
    localparam int LSB = 2, LNAP = 5, LPD = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, grant;
    logic [IDX_W-1:0] grant_chip;
    logic [ADDR_W-1:0] grant_addr;
    logic quad_mode = 1'b1;
    logic [1:0] base_state = 2'd1;
    logic [CNT_W-1:0] thr_a2s = CNT_W'(TAS), thr_s2n = CNT_W'(TSN), thr_n2p = CNT_W'(TNP);
    logic [LAT_W-1:0] wake_stby = LAT_W'(LSB), wake_nap = LAT_W'(LNAP), wake_pdn = LAT_W'(LPD);
    logic force_valid = 1'b0;
    logic [IDX_W-1:0] force_chip = '0;
    logic [1:0] force_state = '0;
    logic [2*NCHIP-1:0] chip_state;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {int chip; int when; int addr;} exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_pwr_ctrl #(.NCHIP(NCHIP), .CHIP_AW(CHIP_AW), .CNT_W(CNT_W), .LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .grant(grant), .grant_chip(grant_chip),
        .grant_addr(grant_addr), .quad_mode(quad_mode), .base_state(base_state),
        .thr_a2s(thr_a2s), .thr_s2n(thr_s2n), .thr_n2p(thr_n2p),
        .wake_stby(wake_stby), .wake_nap(wake_nap), .wake_pdn(wake_pdn),
        .force_valid(force_valid), .force_chip(force_chip),
        .force_state(force_state), .chip_state(chip_state));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int st(input int i);
        return int'(chip_state[2*i +: 2]);
    endfunction

    function automatic int lat_of(input int s);
        case (s)
            0: return 0;
            1: return LSB;
            2: return LNAP;
            default: return LPD;
        endcase
    endfunction

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Present a request at a negedge; returns after the acceptance edge.
    task automatic start_req(input int a);
        int ch;
        int l;
        exp_t e;
        ch = a >> CHIP_AW;
        l = lat_of(st(ch));
        req_valid = 1'b1;
        req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        e.chip = ch; e.when = cyc + l; e.addr = a;
        sb_q.push_back(e);
        check(req_ready == 1'b0, "R5 ready low after accept", int'(req_ready), 0);
        check(st(ch) == 0, "R3 target Active after accept", st(ch), 0);
    endtask

    task automatic wait_free();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic send(input int a);
        start_req(a);
        wait_free();
    endtask

    // Monitor: compares each grant against the head of the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && grant) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5 unexpected grant", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(grant_chip) == e.chip, "R1 grant device", int'(grant_chip), e.chip);
                    check(int'(grant_addr) == e.addr, "R1 grant address", int'(grant_addr), e.addr);
                    check(cyc == e.when, "R4 grant cycle", cyc, e.when);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R2 / R11: reset values seen before the first active edge
        check(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
        check(grant == 1'b0, "R2 grant after reset", int'(grant), 0);
        check(chip_state == '0, "R2 all Active (R11 code 0)", int'(chip_state), 0);

        // R6 quad descent boundaries, thresholds 2/3/4
        step(2);
        check(st(1) == 0, "R6 still Active after 2 idle edges", st(1), 0);
        step(1);
        check(st(1) == 1, "R6 Standby at edge 3", st(1), 1);
        step(3);
        check(st(1) == 1, "R6 still Standby", st(1), 1);
        step(1);
        check(st(1) == 2, "R6 Nap", st(1), 2);
        step(4);
        check(st(3) == 2, "R6 still Nap", st(3), 2);
        step(1);
        check(chip_state == 8'hFF, "R6 all PowerDown", int'(chip_state), 255);
        step(6);
        check(st(0) == 3, "R6 PowerDown held", st(0), 3);

        // Scoreboard traffic: wake from PowerDown, then back-to-back on Active
        send(12'h805);
        check(st(2) == 0, "R9 no idle count while held", st(2), 0);
        check(st(0) == 3, "R9 other device untouched", st(0), 3);
        send(12'hBFF);
        send(12'h400);
        send(12'h3FF);
        step(14);
        send(12'h3FE);

        // Dual mode, base Nap
        quad_mode = 1'b0;
        base_state = 2'd2;
        step(1);
        check(chip_state == 8'hAA, "R8 all to base Nap", int'(chip_state), 170);
        send(12'h010);
        check(st(0) == 0, "R8 Active through grant edge", st(0), 0);
        step(1);
        check(st(0) == 2, "R8 back to base", st(0), 2);

        // Override in quad mode
        quad_mode = 1'b1;
        force_valid = 1'b1; force_chip = 2'd3; force_state = 2'd0;
        step(1);
        force_valid = 1'b0;
        check(st(3) == 0, "R10 force applied", st(3), 0);
        start_req(12'h7A0);
        force_valid = 1'b1; force_chip = 2'd1; force_state = 2'd3;
        step(1);
        force_valid = 1'b0;
        check(st(1) == 0, "R10 force ignored on held device", st(1), 0);
        wait_free();

        // Zero threshold
        thr_a2s = '0;
        send(12'hC33);
        check(st(3) == 0, "R7 Active at grant edge", st(3), 0);
        step(1);
        check(st(3) == 1, "R7 zero threshold drops at once", st(3), 1);

        step(3);
        check(sb_q.size() == 0, "R4 all grants seen", sb_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule